// File: doc/BRIEF.md
# Toggle-Written Random-Access Scan Register Array

This block is a grid of scan-accessible state bits for a random-access test scheme. Sixteen one-bit cells sit on a 4x4 grid. Each cell is selected by one row line and one column line. Two small one-hot decoders drive these lines from a binary cell address. The upper address bits pick the row and the lower bits pick the column.

In functional operation the system clock enable is high and every decoded line is forced low, so each cell loads its functional data input on the clock edge. In test operation the system clock enable is low and the decoder enable acts as a one-cycle strobe. The cell at the intersection of the active row and column inverts its stored bit, and every other cell keeps its value.

Because cells are written only by inverting them, no serial scan-in wire and no per-cell test-control wire is needed. To load a target pattern, a tester reads the addressed bit on the read-data output and strobes a toggle wherever that bit differs from the target. All cell values are also visible in parallel.

Top module: `tras_array`

## Requirements
- R1: A synchronous active-high reset clears all 16 cells, so `state_q` reads 0 after the edge on which `rst` is high.
- R2: With `func_en` = 1, every cell loads its bit of `func_d` on the next rising edge, so `state_q` equals the `func_d` presented before that edge.
- R3: With `func_en` = 1, a toggle request (`dec_en` = 1) at any address has no effect, and the cells still load `func_d`.
- R4: With `func_en` = 0 and `dec_en` = 1 for one cycle, the cell with index row*4+col inverts its bit. Here row is `addr[3:2]` and col is `addr[1:0]`, so the cell index equals the numeric value of `addr`.
- R5: During a toggle strobe, every cell other than the addressed one keeps its value, so at most one bit of `state_q` changes per cycle while `func_en` = 0.
- R6: With `func_en` = 0 and `dec_en` = 0, all cells hold their values whatever `func_d` and `addr` do.
- R7: `rd_bit` combinationally shows the bit of the cell selected by `addr`, meaning `state_q[addr]`.
- R8: Two toggle strobes at the same address restore that cell's original value. Any 16-bit pattern can be reached from any start by reading each bit and toggling it where it differs from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | 1 | System clock enable: functional capture when high |
| dec_en | input | 1 | Decoder enable, used as a one-cycle toggle strobe |
| addr | input | 4 | Cell address: [3:2] row, [1:0] column |
| func_d | input | 16 | Functional data, one bit per cell |
| state_q | output | 16 | Parallel cell values |
| rd_bit | output | 1 | Value of the addressed cell |

## Verification
The bench walks a toggle through all sixteen addresses, one at a time, against a cleared array and against a patterned array. A design that swapped the row and column halves, or mapped the cell index wrongly, would flip the wrong bit. A design whose decoder leaked onto a second line would flip more than one bit. The bench asserts the toggle strobe during functional capture, so a design that lets the toggle win would corrupt one captured bit. It also changes the data and address while idle, so a design that captures or toggles without an enable would drift. Finally, it loads arbitrary patterns using only read-and-toggle, which exposes a read path that points at a different cell than the write path.

// File: rtl/tras_pkg.sv
package tras_pkg;

    localparam int unsigned DEF_ROWS = 4;
    localparam int unsigned DEF_COLS = 4;

    // Control seen by a single cell
    typedef struct packed {
        logic cap;   // system clock enable
        logic row;   // decoded row line
        logic col;   // decoded column line
    } cell_ctl_t;

    typedef enum logic [1:0] {
        CELL_HOLD    = 2'd0,
        CELL_CAPTURE = 2'd1,
        CELL_TOGGLE  = 2'd2
    } cell_mode_e;

    // Capture has priority; toggle needs both lines; otherwise hold
    function automatic cell_mode_e cell_mode(input cell_ctl_t c);
        if (c.cap)
            return CELL_CAPTURE;
        else if (c.row && c.col)
            return CELL_TOGGLE;
        else
            return CELL_HOLD;
    endfunction

endpackage

// File: rtl/tras_decoder.sv
module tras_decoder #(
    parameter int unsigned N = 4,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] sel,
    output logic [N-1:0] lines
);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines[i] = en && (sel == W'(i));
    end

    AST_LINES_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lines));                                        // R5
    AST_LINES_ENABLED: assert property (@(posedge clk) disable iff (rst)
        en |-> $onehot(lines));                                  // R4
    AST_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |-> (lines == '0));                                  // R6

endmodule

// File: rtl/tras_cell.sv
module tras_cell
    import tras_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_ctl_t ctl,
    input  logic      d,
    output logic      q
);

    cell_mode_e mode;
    logic       q_nxt;

    always_comb begin
        mode = cell_mode(ctl);
        unique case (mode)
            CELL_CAPTURE: q_nxt = d;
            CELL_TOGGLE:  q_nxt = ~q;
            default:      q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= q_nxt;
    end

    AST_CELL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl.cap)) |-> (q == $past(d)));   // R2
    AST_CELL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.cap) && $past(ctl.row) && $past(ctl.col))
            |-> (q != $past(q)));                                // R4
    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.cap) && !($past(ctl.row) && $past(ctl.col)))
            |-> $stable(q));                                     // R6

endmodule

// File: rtl/tras_array.sv
module tras_array
    import tras_pkg::*;
#(
    parameter int unsigned ROWS = DEF_ROWS,
    parameter int unsigned COLS = DEF_COLS,
    localparam int unsigned RW = $clog2(ROWS),
    localparam int unsigned CW = $clog2(COLS),
    localparam int unsigned N  = ROWS * COLS,
    localparam int unsigned AW = RW + CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          func_en,
    input  logic          dec_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  func_d,
    output logic [N-1:0]  state_q,
    output logic          rd_bit
);

    logic            strobe;
    logic [ROWS-1:0] row_ln;
    logic [COLS-1:0] col_ln;

    // Decoded lines stay low during functional capture
    assign strobe = dec_en && !func_en;

    tras_decoder #(.N(ROWS)) u_row_dec (
        .clk   (clk),
        .rst   (rst),
        .en    (strobe),
        .sel   (addr[AW-1:CW]),
        .lines (row_ln)
    );

    tras_decoder #(.N(COLS)) u_col_dec (
        .clk   (clk),
        .rst   (rst),
        .en    (strobe),
        .sel   (addr[CW-1:0]),
        .lines (col_ln)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            cell_ctl_t ctl;
            assign ctl.cap = func_en;
            assign ctl.row = row_ln[r];
            assign ctl.col = col_ln[c];
            tras_cell u_cell (
                .clk (clk),
                .rst (rst),
                .ctl (ctl),
                .d   (func_d[r*COLS+c]),
                .q   (state_q[r*COLS+c])
            );
        end
    end

    assign rd_bit = state_q[addr];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (state_q == '0));                         // R1
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(func_en))
            |-> ($countones(state_q ^ $past(state_q)) <= 1));    // R5
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(func_en)) |-> (state_q == $past(func_d))); // R3

endmodule

// File: tb/tras_array_tb.sv
module tras_array_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        func_en;
    logic        dec_en;
    logic [3:0]  addr;
    logic [15:0] func_d;
    logic [15:0] state_q;
    logic        rd_bit;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q;

    always #4 clk = ~clk;   // 125 MHz

    tras_array u_dut (
        .clk     (clk),
        .rst     (rst),
        .func_en (func_en),
        .dec_en  (dec_en),
        .addr    (addr),
        .func_d  (func_d),
        .state_q (state_q),
        .rd_bit  (rd_bit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive on falling edge, sample shortly after the rising edge
    task automatic cycle(input logic fe, input logic de, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        func_en = fe; dec_en = de; addr = a; func_d = d;
        @(posedge clk);
        #1;
        func_en = 1'b0; dec_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; func_en = 1'b1; dec_en = 1'b0; addr = '0; func_d = 16'hFFFF;
        @(posedge clk); #1;
        check("R1 reset clears", state_q, 16'h0);
        @(negedge clk);
        rst = 1'b0; func_en = 1'b0;
        exp_q = '0;
    endtask

    task automatic t_capture();
        logic [15:0] pats [4] = '{16'hA5C3, 16'hFFFF, 16'h0001, 16'h8000};
        foreach (pats[i]) begin
            cycle(1'b1, 1'b0, 4'(i), pats[i]);
            check("R2 capture", state_q, pats[i]);
        end
        exp_q = 16'h8000;
    endtask

    task automatic t_capture_beats_toggle();
        for (int a = 0; a < 16; a += 5) begin
            cycle(1'b1, 1'b1, 4'(a), 16'h3C96);
            check("R3 toggle ignored in capture", state_q, 16'h3C96);
        end
        exp_q = 16'h3C96;
    endtask

    task automatic t_toggle_walk();
        for (int a = 0; a < 16; a++) begin
            cycle(1'b0, 1'b1, 4'(a), 16'hFFFF);
            exp_q[a] = ~exp_q[a];
            check("R4/R5 toggle one cell", state_q, exp_q);
        end
    endtask

    task automatic t_idle_hold();
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, 4'(i * 3), ~exp_q);
            check("R6 idle hold", state_q, exp_q);
        end
    endtask

    task automatic t_read();
        @(negedge clk);
        func_en = 1'b0; dec_en = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a);
            #1;
            check("R7 read addressed cell", 32'(rd_bit), 32'(exp_q[a]));
        end
    endtask

    task automatic t_double_toggle();
        logic [15:0] start = state_q;
        cycle(1'b0, 1'b1, 4'd9, '0);
        cycle(1'b0, 1'b1, 4'd9, '0);
        check("R8 double toggle restores", state_q, start);
    endtask

    task automatic t_load_pattern(input logic [15:0] target);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            addr = 4'(a);
            #1;
            if (rd_bit !== target[a])
                cycle(1'b0, 1'b1, 4'(a), '0);
        end
        check("R8 load pattern by toggling", state_q, target);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; func_en = 1'b0; dec_en = 1'b0; addr = '0; func_d = '0;
        exp_q = '0;
        t_reset();
        t_toggle_walk();
        t_capture();
        t_toggle_walk();
        t_capture_beats_toggle();
        t_idle_hold();
        t_read();
        t_double_toggle();
        t_load_pattern(16'h1E2D);
        t_load_pattern(16'hC0F3);
        exp_q = 16'hC0F3;
        t_read();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule